// File: doc/BRIEF.md
# I2C SCL Prescale Timing Generator

This block builds the serial clock for an I2C master from a programmable prescale value P. While enabled, it drives SCL low for 3·P system clocks and then releases it high for 2·P clocks, so one SCL period is 5·P clocks and the low phase always comes first. Alongside the clock, it produces a sample strobe for an input glitch filter. The strobe repeats every P/4−1 clocks, and its count restarts at the beginning of every low phase.

Two filter lanes, one for SDA and one for SCL, sample the raw bus levels on each strobe. A lane changes its filtered output only when two consecutive samples agree. A byte engine uses the filtered levels and the SCL drive level. The byte engine itself is not part of this block.

A new prescale value is picked up only when a low phase starts. This keeps the current SCL period whole, and the sample spacing is taken from the same latched value. Prescale values below 8 are raised to 8, so the sample spacing never drops below one clock.

Top module: `scl_prescale_gen`

## Requirements
- R1: During reset and right after it, scl_o is 1, smp_stb_o is 0, and both sda_filt_o and scl_filt_o are 1.
- R2: In the cycle after a clock edge that samples en_i low, scl_o is 1 and smp_stb_o is 0, and both phase counters are zero. The next enable therefore begins a complete low phase.
- R3: At a clock edge where en_i is sampled high and the block was idle, a period begins. From the next cycle, scl_o is 0 for exactly 3·P cycles.
- R4: The low phase is followed by exactly 2·P cycles with scl_o at 1. The 5·P-cycle period then repeats for as long as en_i stays high.
- R5: The effective prescale is P = max(prescale_i, 8).
- R6: Cycle t is counted from 0 at the start of each low phase. smp_stb_o is 1 in exactly those running cycles where t mod S = S−1, with S = floor(P/4)−1.
- R7: On a strobe cycle, each lane stores its raw input as the new previous sample. The lane's filtered output takes the raw value only if that value equals the previous sample. In every other case the filtered output holds its value. Lane values are 1 for high and 0 for low. The SDA lane is sda_i to sda_filt_o, and the SCL lane is scl_i to scl_filt_o.
- R8: A change of prescale_i in the middle of a period does not affect the current period. It takes effect from the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for the SCL generator and the filter |
| prescale_i | input | 16 | Prescale value in clocks per unit |
| sda_i | input | 1 | Raw SDA level from the pad |
| scl_i | input | 1 | Raw SCL level from the pad |
| scl_o | output | 1 | SCL drive level: 0 pulls the line low, 1 releases it |
| smp_stb_o | output | 1 | Filter sample strobe |
| sda_filt_o | output | 1 | Filtered SDA |
| scl_filt_o | output | 1 | Filtered SCL |

## Verification
If the phase counter is off by one, the low-to-high edge of scl_o moves by one cycle within the first period after enable. A late-latched prescale value changes the length of the very next period. A divider that slips phase moves the strobe relative to the low-phase start within a few cycles, because the divider restarts every period. A filter lane that accepts a single disagreeing sample shows a wrong filtered level on the strobe right after that sample. Every one of these faults is therefore visible at the ports within one SCL period of its cause.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned NLINES   = 2;
  localparam int unsigned LINE_SDA = 0;
  localparam int unsigned LINE_SCL = 1;
endpackage

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int unsigned PW      = 16,
  parameter int unsigned MIN_PRE = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] prescale_i,
  output logic          run_o,
  output logic          restart_o,
  output logic [PW-1:0] pre_o,
  output logic          scl_o
);
  localparam int unsigned CW = PW + 3;

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_clamp;
  logic [CW-1:0] low_len, last_cnt;
  logic          wrap;

  assign pre_clamp = (prescale_i < PW'(MIN_PRE)) ? PW'(MIN_PRE) : prescale_i;
  assign low_len   = {3'b000, pre_q} * CW'(3);
  assign last_cnt  = ({3'b000, pre_q} * CW'(5)) - CW'(1);
  assign wrap      = run_q && (cnt_q == last_cnt);
  assign restart_o = en_i && (!run_q || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pre_q <= PW'(MIN_PRE);
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || wrap) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      pre_q <= pre_clamp;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign run_o = run_q;
  assign pre_o = pre_q;
  assign scl_o = !run_q || (cnt_q >= low_len);

  AST_PRE_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pre_q >= PW'(MIN_PRE)));  // R5
  AST_PRE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !wrap) |=> $stable(pre_q));  // R8
  AST_LOW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !scl_o);  // R3
endmodule

// File: rtl/smp_div.sv
module smp_div #(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [PW-3:0] pre_q4_i,
  output logic          stb_o
);
  localparam int unsigned DW = PW - 2;

  logic [DW-1:0] sc_q, s_last;

  assign s_last = pre_q4_i - DW'(2);
  assign stb_o  = run_i && (sc_q == s_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sc_q <= '0;
    else if (!en_i || restart_i) sc_q <= '0;
    else if (stb_o)              sc_q <= '0;
    else                         sc_q <= sc_q + DW'(1);
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (sc_q <= s_last));  // R6
endmodule

// File: rtl/glitch_filt.sv
module glitch_filt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic raw_i,
  output logic filt_o
);
  logic prev_q, filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      filt_q <= 1'b1;
    end else if (stb_i) begin
      prev_q <= raw_i;
      if (raw_i == prev_q) filt_q <= raw_i;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(filt_o));  // R7
endmodule

// File: rtl/scl_prescale_gen.sv
module scl_prescale_gen
  import scl_pkg::*;
#(
  parameter int unsigned PW      = 16,
  parameter int unsigned MIN_PRE = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] prescale_i,
  input  logic          sda_i,
  input  logic          scl_i,
  output logic          scl_o,
  output logic          smp_stb_o,
  output logic          sda_filt_o,
  output logic          scl_filt_o
);
  logic          run, restart;
  logic [PW-1:0] pre_q;
  logic [NLINES-1:0] raw, filt;

  scl_phase_gen #(.PW(PW), .MIN_PRE(MIN_PRE)) u_phase (
    .clk_i, .rst_ni, .en_i, .prescale_i,
    .run_o(run), .restart_o(restart), .pre_o(pre_q), .scl_o(scl_o)
  );

  smp_div #(.PW(PW)) u_div (
    .clk_i, .rst_ni, .en_i, .restart_i(restart), .run_i(run),
    .pre_q4_i(pre_q[PW-1:2]), .stb_o(smp_stb_o)
  );

  assign raw[LINE_SDA] = sda_i;
  assign raw[LINE_SCL] = scl_i;

  for (genvar g = 0; g < NLINES; g++) begin : g_lane
    glitch_filt u_filt (
      .clk_i, .rst_ni, .stb_i(smp_stb_o), .raw_i(raw[g]), .filt_o(filt[g])
    );
  end

  assign sda_filt_o = filt[LINE_SDA];
  assign scl_filt_o = filt[LINE_SCL];

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !smp_stb_o));  // R2
endmodule

// File: tb/sim_scl_prescale_gen.sv
module sim_scl_prescale_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, sda = 1'b1, scl = 1'b1;
  logic [15:0] pre = 16'd8;
  logic scl_o, stb_o, sda_f, scl_f;

  int nchk = 0, nerr = 0;
  bit done = 0;
  string phase_tag = "";

  int m_run = 0, m_t = 0, m_p = 8;
  int prev_d = 1, prev_c = 1, f_d = 1, f_c = 1;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  scl_prescale_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .prescale_i(pre),
    .sda_i(sda), .scl_i(scl), .scl_o(scl_o), .smp_stb_o(stb_o),
    .sda_filt_o(sda_f), .scl_filt_o(scl_f)
  );

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0d p=%0d", tag, phase_tag, act, exp, m_t, m_p);
    end
  endtask

  function automatic int clampv(input int v);
    return (v < 8) ? 8 : v;
  endfunction

  task automatic step(input logic e, input logic [15:0] pv, input logic d, input logic c);
    int s, exp_scl, exp_stb;
    @(negedge clk);
    s = m_p / 4 - 1;
    exp_scl = (m_run == 0 || m_t >= 3 * m_p) ? 1 : 0;
    exp_stb = (m_run != 0 && (m_t % s) == s - 1) ? 1 : 0;
    chk(int'(scl_o), exp_scl, "R3 R4");
    chk(int'(stb_o), exp_stb, "R6");
    chk(int'(sda_f), f_d, "R7");
    chk(int'(scl_f), f_c, "R7");
    en = e; pre = pv; sda = d; scl = c;
    if (exp_stb != 0) begin
      if (int'(d) == prev_d) f_d = int'(d);
      if (int'(c) == prev_c) f_c = int'(c);
      prev_d = int'(d); prev_c = int'(c);
    end
    if (!e) begin
      m_run = 0; m_t = 0;
    end else if (m_run == 0 || m_t == 5 * m_p - 1) begin
      m_run = 1; m_t = 0; m_p = clampv(int'(pv));
    end else begin
      m_t++;
    end
  endtask

  task automatic run_cycles(input int n, input logic [15:0] pv, input int hold);
    logic d, c;
    d = 1'b1; c = 1'b1;
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((i % hold) == 0) begin d = lfsr[0]; c = lfsr[3]; end
      step(1'b1, pv, d, c);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(scl_o), 1, "R1");
    chk(int'(stb_o), 0, "R1");
    chk(int'(sda_f), 1, "R1");
    chk(int'(scl_f), 1, "R1");
    rst_n = 1'b1;
    phase_tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 16'd8, 1'b0, 1'b0);

    // main sweep, including clamped values
    foreach (sweep_p[k]) begin
      phase_tag = (sweep_p[k] < 8) ? "R5" : "";
      run_cycles(10 * clampv(sweep_p[k]) + 3, 16'(sweep_p[k]), 1 + (k % 4));
      phase_tag = "R2";
      for (int i = 0; i < 4; i++) step(1'b0, 16'(sweep_p[k]), ~sda, ~scl);
    end

    // prescale change mid-period
    phase_tag = "R8";
    run_cycles(7, 16'd12, 3);
    run_cycles(60 + 100 + 20, 16'd20, 2);
    run_cycles(30, 16'd9, 5);
    run_cycles(120, 16'd9, 1);
    phase_tag = "R2";
    for (int i = 0; i < 10; i++) step(1'b0, 16'd9, i[0], ~i[0]);

    // steady levels pass through the filter
    phase_tag = "R7";
    for (int i = 0; i < 200; i++) step(1'b1, 16'd16, 1'b0, 1'b1);
    chk(int'(sda_f), 0, "R7");
    for (int i = 0; i < 200; i++) step(1'b1, 16'd16, 1'b1, 1'b0);
    chk(int'(scl_f), 0, "R7");
    finish_run();
  end

  int sweep_p[12] = '{0, 3, 7, 8, 9, 11, 12, 13, 16, 17, 23, 40};
endmodule